// File: doc/BRIEF.md
# Memory transparent test-mode controller

This block watches the control pins of a slave memory device and decides when the device drops out of normal operation into a transparent test mode and when it comes back. No extra pin is used. Test entry and exit are recognised either from a command code captured on a strobe, or from a timed write-enable/chip-select combination that normal traffic never produces. A parameter picks one of the two trigger methods. Everything around the block is outside its scope: the storage array, the combinational test network, and any analog-level, clock-rate or dedicated-pin entry scheme.

In command mode a two-bit mode code is taken on every clock edge where the strobe is high. The read and write codes are also kept as the current normal command. In timed-pin mode, write-enable and chip-select first pass through a two-flop synchronizer. A counter then measures how long the condition lasts, in clock cycles. A long hold enters test mode. A short pulse seen while in test mode leaves it.

An optional power-up check can start the device in test mode. For this, a chosen pair of pin levels must be present at a fixed number of cycles after reset is released. Thresholds are given in microseconds together with the clock rate in MHz. The block turns them into cycle counts.

Top module: `ttm_ctrl`

## Requirements
- R1: While rst_ni is low, and after release when no power-up entry happens, test_mode_o is 0 and cmd_wr_o is 0 (read).
- R2: In command mode (TRIG = TRIG_CMD), mode_sel_i is acted on only at a rising clock edge where strobe_i is 1. Without the strobe, neither output changes.
- R3: Code 2'b10 sets test_mode_o and code 2'b11 clears it. The change is visible from the strobed edge on.
- R4: Code 2'b00 makes cmd_wr_o 0 and code 2'b01 makes it 1, from the strobed edge on. This happens in both normal and test mode.
- R5: A read or write code leaves test_mode_o unchanged. A second enter code while already in test mode has no effect, and an exit code while in normal mode has no effect.
- R6: In timed-pin mode (TRIG = TRIG_NFS), the condition is we_ni low with cs_ni high. If it is sampled at ENTER_CYC = CLK_MHZ*ENTER_US consecutive edges, test_mode_o rises two edges after the last of them. One edge fewer does not enter.
- R7: In test mode, a condition pulse sampled at L edges with 1 <= L < EXIT_CYC = CLK_MHZ*EXIT_US clears test_mode_o at edge L+3, counting the first sampled edge as edge 1.
- R8: A pulse of EXIT_CYC up to ENTER_CYC-1 edges changes nothing in either state. A pulse shorter than EXIT_CYC changes nothing in normal mode.
- R9: In timed-pin mode, strobe_i and mode_sel_i are ignored and cmd_wr_o stays 0. In command mode, we_ni and cs_ni have no effect apart from the power-up check.
- R10: With PWRUP_EN set, the synchronized {we_ni, cs_ni} is compared once, at the PWRUP_CYC-th edge after reset release. If it equals PWRUP_LVL, test mode is entered. Otherwise the device stays in normal mode. With PWRUP_EN clear, no such entry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_ni | input | 1 | Memory write-enable pin, active low |
| cs_ni | input | 1 | Memory chip-select pin, active low |
| strobe_i | input | 1 | Capture qualifier for mode_sel_i (command mode) |
| mode_sel_i | input | 2 | Mode code: 00 read, 01 write, 10 enter test, 11 exit test |
| test_mode_o | output | 1 | High while the transparent test mode is active |
| cmd_wr_o | output | 1 | Last captured normal command: 0 read, 1 write |

## Verification
A wrong count or a missing synchronizer stage shows up as test_mode_o moving one or more edges early or late. It can also show up as the flag moving on a pulse whose length sits exactly on a threshold. The bench drives pulses of length ENTER_CYC-1, ENTER_CYC, EXIT_CYC-1, EXIT_CYC and 1 edge so that such slips are visible in the first cycle they occur. A wrong decode or a lost capture register shows on test_mode_o or cmd_wr_o one edge after the strobe. Because the outputs are compared with the model on every clock, any divergence is reported in the cycle it first appears.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
  typedef enum logic {
    TRIG_CMD = 1'b0,
    TRIG_NFS = 1'b1
  } trig_e;

  typedef enum logic [1:0] {
    CODE_RD    = 2'b00,
    CODE_WR    = 2'b01,
    CODE_ENTER = 2'b10,
    CODE_EXIT  = 2'b11
  } code_e;
endpackage

// File: rtl/ttm_sync.sv
module ttm_sync #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/ttm_cmd_dec.sv
module ttm_cmd_dec (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic [1:0] code_i,
  output logic       enter_o,
  output logic       exit_o,
  output logic       wr_o
);
  import ttm_pkg::*;

  code_e code;
  logic  wr_q;

  assign code    = code_e'(code_i);
  assign enter_o = strobe_i && (code == CODE_ENTER);
  assign exit_o  = strobe_i && (code == CODE_EXIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             wr_q <= 1'b0;
    else if (strobe_i && code == CODE_RD)    wr_q <= 1'b0;
    else if (strobe_i && code == CODE_WR)    wr_q <= 1'b1;
  end

  assign wr_o = wr_q;
endmodule

// File: rtl/ttm_nfs_timer.sv
module ttm_nfs_timer #(
  parameter int ENTER_CYC = 37500,
  parameter int EXIT_CYC  = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic enter_o,
  output logic exit_o
);
  localparam int CW = $clog2(ENTER_CYC + 1);

  logic [CW-1:0] run_q;

  // run_q holds the number of consecutive sampled-high edges, saturating
  assign enter_o = cond_i && (run_q == CW'(ENTER_CYC - 1));
  assign exit_o  = !cond_i && (run_q != '0) && (run_q < CW'(EXIT_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          run_q <= '0;
    else if (!cond_i)                     run_q <= '0;
    else if (run_q != CW'(ENTER_CYC))     run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/ttm_pwrup.sv
module ttm_pwrup #(
  parameter int         PU_CYC = 1000,
  parameter logic [1:0] LVL    = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] lvl_i,
  output logic       fire_o
);
  localparam int PW = $clog2(PU_CYC + 1);

  logic [PW-1:0] cnt_q;
  logic          done_q;
  logic          at_sample;

  assign at_sample = !done_q && (cnt_q == PW'(PU_CYC - 1));
  assign fire_o    = at_sample && (lvl_i == LVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q  <= cnt_q + 1'b1;
      done_q <= at_sample;
    end
  end
endmodule

// File: rtl/ttm_ctrl.sv
module ttm_ctrl #(
  parameter ttm_pkg::trig_e TRIG      = ttm_pkg::TRIG_CMD,
  parameter int             CLK_MHZ   = 250,
  parameter int             ENTER_US  = 150,
  parameter int             EXIT_US   = 100,
  parameter bit             PWRUP_EN  = 1'b0,
  parameter int             PWRUP_CYC = 1000,
  parameter logic [1:0]     PWRUP_LVL = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_ni,
  input  logic       cs_ni,
  input  logic       strobe_i,
  input  logic [1:0] mode_sel_i,
  output logic       test_mode_o,
  output logic       cmd_wr_o
);
  import ttm_pkg::*;

  localparam int ENTER_CYC = CLK_MHZ * ENTER_US;
  localparam int EXIT_CYC  = CLK_MHZ * EXIT_US;

  logic [1:0] pin_s;   // {we, cs} synchronized
  logic       cond_s;
  logic       enter, leave, pu_fire;
  logic       tm_q;
  logic       unused_sink;

  ttm_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({we_ni, cs_ni}),
    .q_o   (pin_s)
  );

  // write enabled while chip deselected
  assign cond_s = !pin_s[1] && pin_s[0];

  if (TRIG == TRIG_CMD) begin : g_cmd
    ttm_cmd_dec u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strobe_i(strobe_i),
      .code_i  (mode_sel_i),
      .enter_o (enter),
      .exit_o  (leave),
      .wr_o    (cmd_wr_o)
    );
  end else begin : g_nfs
    ttm_nfs_timer #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cond_i (cond_s),
      .enter_o(enter),
      .exit_o (leave)
    );
    assign cmd_wr_o = 1'b0;
  end

  if (PWRUP_EN) begin : g_pu
    ttm_pwrup #(.PU_CYC(PWRUP_CYC), .LVL(PWRUP_LVL)) u_pu (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (pin_s),
      .fire_o(pu_fire)
    );
  end else begin : g_no_pu
    assign pu_fire = 1'b0;
  end

  assign unused_sink = ^{strobe_i, mode_sel_i, pin_s, cond_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tm_q <= 1'b0;
    else if (pu_fire) tm_q <= 1'b1;
    else if (enter)   tm_q <= 1'b1;
    else if (leave)   tm_q <= 1'b0;
  end

  assign test_mode_o = tm_q;
endmodule

// File: rtl/ttm_ctrl_chk.sv
module ttm_ctrl_chk #(
  parameter ttm_pkg::trig_e TRIG = ttm_pkg::TRIG_CMD
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       strobe_i,
  input logic [1:0] mode_sel_i,
  input logic       test_mode_o,
  input logic       cmd_wr_o,
  input logic       pu_fire_i,
  input logic       cond_s_i
);
  import ttm_pkg::*;

  logic unused_chk;
  assign unused_chk = ^{strobe_i, mode_sel_i, cmd_wr_o, cond_s_i};

  if (TRIG == TRIG_CMD) begin : g_cmd
    AST_CMD_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i && mode_sel_i == 2'b10 |=> test_mode_o); // R3
    AST_CMD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i && mode_sel_i == 2'b11 && !pu_fire_i |=> !test_mode_o); // R3
    AST_RDWR_KEEPS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i && !mode_sel_i[1] && !pu_fire_i |=> $stable(test_mode_o)); // R5
    AST_WR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i && mode_sel_i == 2'b01 |=> cmd_wr_o); // R4
    AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !strobe_i && !pu_fire_i |=> $stable(test_mode_o) && $stable(cmd_wr_o)); // R2
  end else begin : g_nfs
    AST_EXIT_AT_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(test_mode_o) |-> $past(cond_s_i) == 1'b0 && $past(cond_s_i, 2) == 1'b1); // R7
    AST_ENTRY_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(test_mode_o) && !$past(pu_fire_i) |-> $past(cond_s_i) && $past(cond_s_i, 2)); // R6
    AST_NFS_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_i |=> !cmd_wr_o); // R9
  end
endmodule

bind ttm_ctrl ttm_ctrl_chk #(.TRIG(TRIG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strobe_i   (strobe_i),
  .mode_sel_i (mode_sel_i),
  .test_mode_o(test_mode_o),
  .cmd_wr_o   (cmd_wr_o),
  .pu_fire_i  (pu_fire),
  .cond_s_i   (cond_s)
);

// File: tb/tb_ttm_ctrl.sv
`timescale 1ns/1ps
module tb_ttm_ctrl;
  import ttm_pkg::*;

  localparam int E  = 150;
  localparam int X  = 100;
  localparam int PU = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we_n = 1'b1, cs_n = 1'b1, strobe = 1'b0;
  logic [1:0] msel = 2'b00;
  logic       tm_a, wr_a, tm_b, wr_b;

  always #2 clk = ~clk;

  ttm_ctrl #(.TRIG(TRIG_NFS), .CLK_MHZ(1), .ENTER_US(E), .EXIT_US(X),
             .PWRUP_EN(1'b1), .PWRUP_CYC(PU), .PWRUP_LVL(2'b00)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_ni(we_n), .cs_ni(cs_n),
    .strobe_i(strobe), .mode_sel_i(msel), .test_mode_o(tm_a), .cmd_wr_o(wr_a));

  ttm_ctrl #(.TRIG(TRIG_CMD), .CLK_MHZ(1), .ENTER_US(E), .EXIT_US(X),
             .PWRUP_EN(1'b0), .PWRUP_CYC(PU), .PWRUP_LVL(2'b00)) dut_cmd (
    .clk_i(clk), .rst_ni(rst_n), .we_ni(we_n), .cs_ni(cs_n),
    .strobe_i(strobe), .mode_sel_i(msel), .test_mode_o(tm_b), .cmd_wr_o(wr_b));

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference state
  bit m_tm, mc_tm, mc_wr;
  bit w1, w2, c1, c2;
  int run, nedge;

  task automatic chk(string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic model_init();
    m_tm = 0; mc_tm = 0; mc_wr = 0;
    w1 = 1; w2 = 1; c1 = 1; c2 = 1;
    run = 0; nedge = 0;
  endtask

  task automatic step();
    bit cnd;
    @(posedge clk);
    cnd = !w2 && c2;
    nedge++;
    if (nedge == PU && !w2 && !c2)       m_tm = 1;
    else if (cnd && run + 1 == E)        m_tm = 1;
    else if (!cnd && run > 0 && run < X) m_tm = 0;
    run = cnd ? run + 1 : 0;
    w2 = w1; w1 = we_n; c2 = c1; c1 = cs_n;
    if (strobe) begin
      case (msel)
        2'b00: mc_wr = 0;
        2'b01: mc_wr = 1;
        2'b10: mc_tm = 1;
        default: mc_tm = 0;
      endcase
    end
    @(negedge clk);
    chk({tag, " pin-timed flag"}, tm_a, m_tm);
    chk({tag, " pin-timed cmd (R9)"}, wr_a, 1'b0);
    chk({tag, " command flag"}, tm_b, mc_tm);
    chk({tag, " command wr"}, wr_b, mc_wr);
  endtask

  task automatic do_reset(bit we, bit cs);
    @(negedge clk);
    rst_n = 0; we_n = we; cs_n = cs; strobe = 0; msel = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 reset flag pin-timed", tm_a, 1'b0);
    chk("R1 reset flag command", tm_b, 1'b0);
    chk("R1 reset wr command", wr_b, 1'b0);
    model_init();
    rst_n = 1;
  endtask

  task automatic pulse(int len);
    we_n = 0; cs_n = 1;
    repeat (len) step();
    we_n = 1; cs_n = 1;
    repeat (6) step();
  endtask

  task automatic cmd(logic [1:0] code);
    msel = code; strobe = 1;
    step();
    strobe = 0;
    step();
  endtask

  initial begin
    model_init();
    // power-up levels present
    tag = "R10 pu met";
    do_reset(1'b0, 1'b0);
    repeat (30) step();
    chk("R10 power-up entry", tm_a, 1'b1);
    chk("R10 disabled option, no entry", tm_b, 1'b0);
    we_n = 1; cs_n = 1;
    repeat (4) step();
    tag = "R7 short exit";
    pulse(10);
    chk("R7 short pulse exit", tm_a, 1'b0);

    // power-up levels absent
    tag = "R10 pu not met";
    do_reset(1'b1, 1'b1);
    repeat (30) step();
    chk("R10 no entry on other levels", tm_a, 1'b0);
    chk("R1 normal after reset", tm_b, 1'b0);

    // command decode
    tag = "R2 no strobe";
    msel = 2'b10;
    repeat (3) step();
    chk("R2 enter code without strobe", tm_b, 1'b0);
    tag = "R3 enter";
    cmd(2'b10);
    chk("R3 enter code", tm_b, 1'b1);
    chk("R9 strobe ignored in pin-timed mode", tm_a, 1'b0);
    tag = "R5 repeat enter";
    cmd(2'b10);
    chk("R5 repeated enter", tm_b, 1'b1);
    tag = "R4 wr in test";
    cmd(2'b01);
    chk("R4 write captured in test mode", wr_b, 1'b1);
    chk("R5 write keeps test mode", tm_b, 1'b1);
    cmd(2'b00);
    chk("R4 read captured", wr_b, 1'b0);
    chk("R5 read keeps test mode", tm_b, 1'b1);
    tag = "R3 exit";
    cmd(2'b11);
    chk("R3 exit code", tm_b, 1'b0);
    tag = "R5 repeat exit";
    cmd(2'b11);
    chk("R5 exit in normal mode", tm_b, 1'b0);
    tag = "R2 no strobe wr";
    msel = 2'b01;
    repeat (3) step();
    chk("R2 write code without strobe", wr_b, 1'b0);
    tag = "R4 wr normal";
    cmd(2'b01);
    chk("R4 write captured in normal mode", wr_b, 1'b1);
    cmd(2'b10);

    // timed-pin method; command instance checked every cycle (R9)
    tag = "R8 normal pulses";
    pulse(50);
    chk("R8 short pulse in normal mode", tm_a, 1'b0);
    pulse(120);
    chk("R8 mid pulse in normal mode", tm_a, 1'b0);
    tag = "R6 threshold-1";
    pulse(E - 1);
    chk("R6 one edge short of entry", tm_a, 1'b0);
    tag = "R6 entry";
    pulse(E);
    chk("R6 entry at threshold", tm_a, 1'b1);
    chk("R9 pins ignored in command mode", tm_b, 1'b1);
    tag = "R8 in test";
    pulse(X);
    chk("R8 pulse at exit limit ignored", tm_a, 1'b1);
    pulse(120);
    chk("R8 mid pulse in test mode", tm_a, 1'b1);
    tag = "R7 exit";
    pulse(X - 1);
    chk("R7 exit just below limit", tm_a, 1'b0);
    tag = "R6 long hold";
    pulse(E + 40);
    chk("R6 entry on long hold", tm_a, 1'b1);
    tag = "R7 one edge";
    pulse(1);
    chk("R7 single-edge pulse exit", tm_a, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule